// File: doc/BRIEF.md
# Chip-Select Transfer Acknowledge Generator

This block decides when a bus access that has hit a chip-select region is complete. When the region-hit strobe is seen with the block idle, it latches the initiator type and the region's acknowledge settings. It then either counts down a programmed number of wait states and acknowledges by itself, or waits for the transfer acknowledge that arrives on the shared, active-low TA line.

Accesses from the internal core and accesses from an external master follow separate auto-acknowledge settings. For external-master accesses, the auto-acknowledge setting also decides whether this block drives the TA pin. When it drives the pin, it enables the tri-state driver for the whole access plus one cycle after the acknowledge. During that extra cycle the line is actively held negated before it is released. The internal `xfer_done` pulse marks completion for both initiator types.

Top module: `cs_ack_gen`

## Requirements
- R1: During and right after reset, `xfer_done` is 0, `ta_out_n` is 1 and `ta_oe` is 0.
- R2: A core access (`from_xm`=0) with `cfg_core_auto`=0 completes only in the first busy cycle where `ta_in_n` is 0. Busy cycles are numbered 1 onward after the cycle in which the strobe was sampled. `xfer_done` is 1 in exactly that cycle.
- R3: A core access with `cfg_core_auto`=1, wait count W (0..15) and no external TA completes with `xfer_done`=1 in busy cycle W+1.
- R4: In a core access with `cfg_core_auto`=1, an external TA in a busy cycle k ≤ W ends the access in cycle k. If the external TA arrives in cycle W+1, together with the wait-state expiry, exactly one `xfer_done` pulse results.
- R5: An external-master access (`from_xm`=1) with `cfg_xm_auto`=1 holds `ta_oe`=1 from busy cycle 1 through cycle W+2. `ta_out_n` is 0 only in cycle W+1, together with `xfer_done`. `ta_in_n` has no effect, and an external TA must never be asserted while `ta_oe` is 1.
- R6: An external-master access with `cfg_xm_auto`=0 keeps `ta_oe`=0 and `ta_out_n`=1, and completes only on an external TA, as in R2.
- R7: Each access gives exactly one `xfer_done` pulse. Strobes and configuration changes during a busy access are ignored. The settings in force are the ones sampled with the accepted strobe.
- R8: While idle, `ta_in_n` has no effect: `xfer_done` stays 0 and `ta_oe` stays 0 outside the R5 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit | input | 1 | Region-hit strobe; starts an access when idle |
| from_xm | input | 1 | 1 = external master access, 0 = core access |
| cfg_core_auto | input | 1 | Auto-acknowledge enable for core accesses |
| cfg_xm_auto | input | 1 | Auto-acknowledge and TA drive enable for external-master accesses |
| cfg_wait | input | WS_W | Wait-state count |
| ta_in_n | input | 1 | Sampled external TA, active low |
| xfer_done | output | 1 | Access complete, one cycle |
| ta_out_n | output | 1 | TA value to drive, active low |
| ta_oe | output | 1 | Tri-state enable for the TA pin |

## Verification
For a core access with auto-acknowledge on, the wait-state expiry and an external TA can occur in the same cycle. The bench provokes this both randomly and with directed cases. In those cases the external TA is placed exactly at busy cycle W+1, and also earlier and later. The reference model expects a single `xfer_done` in the earlier of the two cycles, and it expects idle outputs afterwards, with no second pulse.

// File: rtl/cs_ack_gen.sv
module cs_ack_gen #(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            from_xm,
  input  logic            cfg_core_auto,
  input  logic            cfg_xm_auto,
  input  logic [WS_W-1:0] cfg_wait,
  input  logic            ta_in_n,
  output logic            xfer_done,
  output logic            ta_out_n,
  output logic            ta_oe
);

  logic            busy, is_xm, auto_en, oe_tail;
  logic [WS_W-1:0] cnt;
  logic            drive, wait_ok, ext_ack;

  assign drive   = busy & is_xm & auto_en;
  assign wait_ok = busy & auto_en & (cnt == '0);
  assign ext_ack = busy & ~drive & ~ta_in_n;

  assign xfer_done = wait_ok | ext_ack;
  assign ta_out_n  = ~(drive & wait_ok);
  assign ta_oe     = drive | oe_tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      is_xm   <= 1'b0;
      auto_en <= 1'b0;
      oe_tail <= 1'b0;
      cnt     <= '0;
    end else begin
      oe_tail <= drive & xfer_done;
      if (!busy) begin
        if (hit) begin
          busy    <= 1'b1;
          is_xm   <= from_xm;
          auto_en <= from_xm ? cfg_xm_auto : cfg_core_auto;
          cnt     <= cfg_wait;
        end
      end else if (xfer_done) begin
        busy <= 1'b0;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cs_ack_gen_chk.sv
module cs_ack_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic ta_in_n,
  input logic xfer_done,
  input logic ta_out_n,
  input logic ta_oe
);

  AST_NO_EXT_TA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) ta_oe |-> ta_in_n); // R5
  AST_TA_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n) !ta_out_n |-> ta_oe); // R5
  AST_ACK_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !ta_out_n |-> xfer_done); // R5
  AST_OE_TAIL: assert property (@(posedge clk) disable iff (!rst_n) $fell(ta_oe) |-> $past(ta_out_n) && $past(!ta_out_n, 2)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |=> !xfer_done); // R7

endmodule

bind cs_ack_gen cs_ack_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ta_in_n(ta_in_n),
  .xfer_done(xfer_done), .ta_out_n(ta_out_n), .ta_oe(ta_oe)
);

// File: tb/cs_ack_gen_test.sv
`timescale 1ns/1ps
module cs_ack_gen_test;
  logic clk = 0, rst_n = 0;
  logic hit = 0, from_xm = 0, cfg_core_auto = 0, cfg_xm_auto = 0, ta_in_n = 1;
  logic [3:0] cfg_wait = 0;
  logic xfer_done, ta_out_n, ta_oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cs_ack_gen #(.WS_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .hit(hit), .from_xm(from_xm),
    .cfg_core_auto(cfg_core_auto), .cfg_xm_auto(cfg_xm_auto), .cfg_wait(cfg_wait),
    .ta_in_n(ta_in_n), .xfer_done(xfer_done), .ta_out_n(ta_out_n), .ta_oe(ta_oe)
  );

  task automatic chk(string req, string sig, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, sig, act, exp, $time);
    end
  endtask

  function automatic int done_cycle(bit xm, bit ca, bit xa, int w, int ext_at);
    bit drv = xm & xa;
    bit au = xm ? xa : ca;
    int d = 1000;
    if (au) d = w + 1;
    if (!drv && ext_at > 0 && ext_at < d) d = ext_at;
    return d;
  endfunction

  function automatic string tag(bit xm, bit ca, bit xa, int ext_at, int d);
    if (xm) return xa ? "R5" : "R6";
    if (!ca) return "R2";
    return (ext_at > 0 && ext_at <= d) ? "R4" : "R3";
  endfunction

  task automatic access(bit xm, bit ca, bit xa, int w, int ext_at);
    bit drv = xm & xa;
    int d = done_cycle(xm, ca, xa, w, ext_at);
    string t = tag(xm, ca, xa, ext_at, d);
    @(negedge clk);
    hit = 1; from_xm = xm; cfg_core_auto = ca; cfg_xm_auto = xa; cfg_wait = w[3:0];
    ta_in_n = 1;
    for (int c = 1; c <= d + 1; c++) begin
      @(negedge clk);
      hit = (c <= d) ? 1'($urandom) : 1'b0;
      {from_xm, cfg_core_auto, cfg_xm_auto} = 3'($urandom);
      cfg_wait = 4'($urandom);
      if (c <= d) ta_in_n = drv ? 1'($urandom) & 1'b1 | drv : !(ext_at > 0 && c >= ext_at);
      else ta_in_n = drv ? 1'b1 : 1'($urandom);
      if (drv && c <= d) ta_in_n = 1'b1;
      #1;
      if (c <= d) begin
        chk(t, "xfer_done", xfer_done, c == d);
        chk(t, "ta_out_n", ta_out_n, !(drv && c == d));
        chk(t, "ta_oe", ta_oe, drv);
      end else begin
        chk("R7", "xfer_done", xfer_done, 1'b0);
        chk(drv ? "R5" : "R8", "ta_oe", ta_oe, drv);
        chk("R5", "ta_out_n", ta_out_n, 1'b1);
      end
    end
    @(negedge clk);
    hit = 0; ta_in_n = 1'($urandom);
    #1;
    chk("R8", "xfer_done", xfer_done, 1'b0);
    chk("R8", "ta_oe", ta_oe, 1'b0);
    ta_in_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "xfer_done", xfer_done, 1'b0);
    chk("R1", "ta_out_n", ta_out_n, 1'b1);
    chk("R1", "ta_oe", ta_oe, 1'b0);
    rst_n = 1;
    @(negedge clk); ta_in_n = 0; #1;
    chk("R1", "xfer_done", xfer_done, 1'b0);
    chk("R8", "ta_oe", ta_oe, 1'b0);
    ta_in_n = 1;
    // directed corners
    access(0, 0, 0, 0, 1);   // R2 earliest external TA
    access(0, 0, 1, 3, 9);   // R2 xm_auto has no effect on core
    access(0, 1, 0, 0, 0);   // R3 zero wait states
    access(0, 1, 0, 15, 0);  // R3 maximum wait states
    access(0, 1, 0, 5, 1);   // R4 early external TA
    access(0, 1, 0, 5, 6);   // R4 same cycle as expiry
    access(0, 1, 0, 0, 1);   // R4 same cycle, zero wait
    access(1, 0, 1, 0, 0);   // R5 zero wait
    access(1, 0, 1, 15, 0);  // R5 maximum wait
    access(1, 1, 0, 2, 4);   // R6 core_auto has no effect on xm
    for (int i = 0; i < 300; i++) begin
      bit xm = 1'($urandom), ca = 1'($urandom), xa = 1'($urandom);
      int w = int'($urandom_range(0, 15));
      int e = int'($urandom_range(0, 20));
      if (!(xm ? xa : ca) && e == 0) e = int'($urandom_range(1, 20));
      access(xm, ca, xa, w, e);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule